// File: doc/BRIEF.md
# Integer Status Flag Unit with Branch Condition Test

This unit keeps the five integer status flags of a processor core and decides whether a conditional branch is taken. When an integer compare, add, subtract, add-with-carry or subtract-with-carry is issued at byte, halfword or word width, it works out the new carry (C), general/overflow (F), equal (Z), signed-less (N) and unsigned-less (L) flags from the two operands. It then writes back only the flags that the operation class owns. Every other flag keeps its old value.

A 4-bit condition code is tested against the stored flags without any clock delay. A branch that follows a compare can therefore use the result in the next cycle. The equal/less tests use the dedicated L and N flags, so the condition table needs no carry/overflow arithmetic. N is taken from the exact signed ordering of the operands, so it stays correct even when the truncated difference would overflow.

Top module: `flagcond_unit`

## Requirements
- R1: `size_code` selects the operand width: 00 = 8 bits, 01 = 16 bits, 11 = 32 bits. Only the low bits of that width in each operand affect the flags. An operation issued with size 10 changes no flag.
- R2: `op_sel` is coded as 0 = compare, 1 = add, 2 = subtract, 3 = add-with-carry, 4 = subtract-with-carry. Codes 5, 6 and 7 change no flag.
- R3: A compare evaluates `src_b` − `src_a`. It sets Z when the operands are equal, L when `src_b` < `src_a` as unsigned numbers, and N when `src_b` < `src_a` as signed numbers.
- R4: N after a compare reflects the true signed order even when the width-truncated difference overflows. For example, an 8-bit compare of `src_b`=0x80 with `src_a`=0x01 gives N=1.
- R5: A compare leaves C and F unchanged.
- R6: Add computes `src_b` + `src_a`. It sets C to the carry out of the selected width and F to signed overflow, and leaves Z, N and L unchanged.
- R7: Subtract computes `src_b` − `src_a`. It sets C to the borrow and F to signed overflow, and leaves Z, N and L unchanged.
- R8: Add-with-carry adds the stored C as an extra one. Subtract-with-carry takes the stored C as an extra borrow. Both update C and F in the same way as R6 and R7.
- R9: Flags change only on a rising clock edge with `op_valid` high. The new flags are visible on the outputs after that edge. With `op_valid` low, all flags hold.
- R10: A synchronous active-high `rst` clears all five flags.
- R11: `cond_code` 0..15 tests, in this order: Z=1, Z=0, C=1, C=0, L=1, L=0, N=1, N=0, F=1, F=0, (L|Z)=0, (L|Z)=1, (N|Z)=0, (N|Z)=1, always, never.
- R12: `cond_true` is combinational from the registered flags and `cond_code`. A new code is answered in the same cycle, and the flags of an operation are tested from the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe for the operation on the inputs |
| op_sel | input | 3 | Operation select (R2 coding) |
| size_code | input | 2 | Operand width select (R1 coding) |
| src_a | input | 32 | First operand (subtrahend / addend) |
| src_b | input | 32 | Second operand (minuend / addend) |
| cond_code | input | 4 | Branch condition to test |
| flag_c | output | 1 | Carry / borrow flag |
| flag_f | output | 1 | Overflow / general flag |
| flag_z | output | 1 | Equal flag |
| flag_n | output | 1 | Signed-less flag |
| flag_l | output | 1 | Unsigned-less flag |
| cond_true | output | 1 | Selected condition holds for the stored flags |

## Verification
The flag results of an operation are registered, so they are due one rising edge after the operation is presented with `op_valid` high. The bench drives each operation at a falling edge and compares the flags at the following falling edge, against a reference model that uses wide signed integer arithmetic. `cond_true` has no register of its own. For the sweep over all sixteen codes, the code is changed with `op_valid` low and sampled a nanosecond later, within the same cycle. In the operation vectors it is sampled together with the new flags.

// File: rtl/flagcond_pkg.sv
package flagcond_pkg;

    localparam int WORD_W  = 32;
    localparam int EXT_W   = WORD_W + 1;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;
    localparam int OP_W    = 3;
    localparam int COND_W  = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_BAD  = 2'b10,
        SZ_WORD = 2'b11
    } size_e;

    typedef enum logic [OP_W-1:0] {
        OP_CMP  = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_ADDC = 3'd3,
        OP_SUBC = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [COND_W-1:0] {
        CC_EQ    = 4'd0,
        CC_NE    = 4'd1,
        CC_CSET  = 4'd2,
        CC_CCLR  = 4'd3,
        CC_ULT   = 4'd4,
        CC_UGE   = 4'd5,
        CC_SLT   = 4'd6,
        CC_SGE   = 4'd7,
        CC_FSET  = 4'd8,
        CC_FCLR  = 4'd9,
        CC_NLZ   = 4'd10,
        CC_LZ    = 4'd11,
        CC_NNZ   = 4'd12,
        CC_NZ    = 4'd13,
        CC_ALL   = 4'd14,
        CC_NONE  = 4'd15
    } cond_e;

    typedef struct packed {
        logic c;
        logic f;
        logic z;
        logic n;
        logic l;
    } flags_t;

    typedef struct packed {
        logic [EXT_W-1:0] uval;
        logic [EXT_W-1:0] sval;
    } operand_t;

    function automatic logic size_ok(input size_e sz);
        return sz != SZ_BAD;
    endfunction

    function automatic logic op_ok(input op_e op);
        return op <= OP_SUBC;
    endfunction

    function automatic logic bit_at_width(input logic [EXT_W-1:0] v, input size_e sz);
        logic r;
        case (sz)
            SZ_BYTE: r = v[BYTE_W];
            SZ_HALF: r = v[HALF_W];
            default: r = v[WORD_W];
        endcase
        return r;
    endfunction

    function automatic logic top_bit(input logic [EXT_W-1:0] v, input size_e sz);
        logic r;
        case (sz)
            SZ_BYTE: r = v[BYTE_W-1];
            SZ_HALF: r = v[HALF_W-1];
            default: r = v[WORD_W-1];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flagcond_sizer.sv
module flagcond_sizer
    import flagcond_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  size_e             sz,
    output operand_t          opnd
);
    always_comb begin
        case (sz)
            SZ_BYTE: begin
                opnd.uval = {{(EXT_W-BYTE_W){1'b0}}, raw[BYTE_W-1:0]};
                opnd.sval = {{(EXT_W-BYTE_W){raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
            end
            SZ_HALF: begin
                opnd.uval = {{(EXT_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
                opnd.sval = {{(EXT_W-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
            end
            default: begin
                opnd.uval = {1'b0, raw};
                opnd.sval = {raw[WORD_W-1], raw};
            end
        endcase
    end
endmodule

// File: rtl/flagcond_compute.sv
module flagcond_compute
    import flagcond_pkg::*;
(
    input  op_e      op,
    input  size_e    sz,
    input  operand_t opa,
    input  operand_t opb,
    input  flags_t   cur,
    output flags_t   nxt,
    output logic     upd
);
    logic             is_sub;
    logic             use_cin;
    logic [EXT_W-1:0] cin_ext;
    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] dif_ext;
    logic             sgn_a;
    logic             sgn_b;
    logic             sgn_sum;
    logic             sgn_dif;
    logic             add_ovf;
    logic             sub_ovf;

    always_comb begin
        is_sub  = (op == OP_SUB) || (op == OP_SUBC);
        use_cin = ((op == OP_ADDC) || (op == OP_SUBC)) && cur.c;
        cin_ext = {{(EXT_W-1){1'b0}}, use_cin};
        sum_ext = opb.uval + opa.uval + cin_ext;
        dif_ext = opb.uval - opa.uval - cin_ext;
        sgn_a   = opa.sval[EXT_W-1];
        sgn_b   = opb.sval[EXT_W-1];
        sgn_sum = top_bit(sum_ext, sz);
        sgn_dif = top_bit(dif_ext, sz);
        add_ovf = (sgn_a == sgn_b) && (sgn_sum != sgn_a);
        sub_ovf = (sgn_a != sgn_b) && (sgn_dif != sgn_b);
    end

    always_comb begin
        nxt = cur;
        upd = size_ok(sz) && op_ok(op);
        if (op == OP_CMP) begin
            nxt.z = (opa.uval == opb.uval);
            nxt.l = (opb.uval < opa.uval);
            nxt.n = ($signed(opb.sval) < $signed(opa.sval));
        end else if (is_sub) begin
            nxt.c = dif_ext[EXT_W-1];
            nxt.f = sub_ovf;
        end else begin
            nxt.c = bit_at_width(sum_ext, sz);
            nxt.f = add_ovf;
        end
    end
endmodule

// File: rtl/flagcond_eval.sv
module flagcond_eval
    import flagcond_pkg::*;
(
    input  flags_t fl,
    input  cond_e  code,
    output logic   hit
);
    logic base;

    always_comb begin
        case (code[COND_W-1:1])
            3'd0:    base = fl.z;
            3'd1:    base = fl.c;
            3'd2:    base = fl.l;
            3'd3:    base = fl.n;
            3'd4:    base = fl.f;
            3'd5:    base = ~(fl.l | fl.z);
            3'd6:    base = ~(fl.n | fl.z);
            default: base = 1'b1;
        endcase
        hit = code[0] ? ~base : base;
    end
endmodule

// File: rtl/flagcond_unit.sv
module flagcond_unit
    import flagcond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [1:0]        size_code,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic [COND_W-1:0] cond_code,
    output logic              flag_c,
    output logic              flag_f,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_l,
    output logic              cond_true
);
    operand_t opa;
    operand_t opb;
    flags_t   flags_q;
    flags_t   flags_d;
    logic     can_upd;

    flagcond_sizer u_size_a (.raw(src_a), .sz(size_e'(size_code)), .opnd(opa));
    flagcond_sizer u_size_b (.raw(src_b), .sz(size_e'(size_code)), .opnd(opb));

    flagcond_compute u_comp (
        .op  (op_e'(op_sel)),
        .sz  (size_e'(size_code)),
        .opa (opa),
        .opb (opb),
        .cur (flags_q),
        .nxt (flags_d),
        .upd (can_upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (op_valid && can_upd) begin
            flags_q <= flags_d;
        end
    end

    flagcond_eval u_eval (
        .fl   (flags_q),
        .code (cond_e'(cond_code)),
        .hit  (cond_true)
    );

    assign flag_c = flags_q.c;
    assign flag_f = flags_q.f;
    assign flag_z = flags_q.z;
    assign flag_n = flags_q.n;
    assign flag_l = flags_q.l;
endmodule

// File: rtl/flagcond_checker.sv
module flagcond_checker (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [2:0]  op_sel,
    input logic [1:0]  size_code,
    input logic [31:0] src_a,
    input logic [31:0] src_b,
    input logic [3:0]  cond_code,
    input logic        flag_c,
    input logic        flag_f,
    input logic        flag_z,
    input logic        flag_n,
    input logic        flag_l,
    input logic        cond_true
);
    logic [4:0] fv;
    assign fv = {flag_c, flag_f, flag_z, flag_n, flag_l};

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (fv == 5'b0));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (fv == $past(fv)));

    p_bad_size_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (op_valid && size_code == 2'b10) |=> (fv == $past(fv)));

    p_bad_op_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel > 3'd4) |=> (fv == $past(fv)));

    p_cmp_equal_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd0 && size_code != 2'b10 && src_a == src_b)
        |=> (flag_z && !flag_l && !flag_n));

    p_cmp_keeps_cf_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd0)
        |=> (flag_c == $past(flag_c) && flag_f == $past(flag_f)));

    p_arith_keeps_znl_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel != 3'd0)
        |=> (flag_z == $past(flag_z) && flag_n == $past(flag_n) && flag_l == $past(flag_l)));

    p_always_r11: assert property (@(posedge clk) disable iff (rst)
        (cond_code == 4'd14) |-> cond_true);

    p_never_r11: assert property (@(posedge clk) disable iff (rst)
        (cond_code == 4'd15) |-> !cond_true);
endmodule

bind flagcond_unit flagcond_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .size_code (size_code),
    .src_a     (src_a),
    .src_b     (src_b),
    .cond_code (cond_code),
    .flag_c    (flag_c),
    .flag_f    (flag_f),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .flag_l    (flag_l),
    .cond_true (cond_true)
);

// File: tb/flagcond_unit_bench.sv
module flagcond_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  size_code = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [3:0]  cond_code = '0;
    logic        flag_c, flag_f, flag_z, flag_n, flag_l, cond_true;

    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    logic [4:0] mflags = '0;  // {c,f,z,n,l}

    always #10 clk = ~clk;

    flagcond_unit u_flagcond_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .size_code(size_code), .src_a(src_a), .src_b(src_b),
        .cond_code(cond_code), .flag_c(flag_c), .flag_f(flag_f),
        .flag_z(flag_z), .flag_n(flag_n), .flag_l(flag_l),
        .cond_true(cond_true)
    );

    function automatic logic [4:0] ref_flags(input logic [2:0] op, input logic [1:0] sz,
                                             input logic [31:0] a, input logic [31:0] b,
                                             input logic [4:0] cur);
        longint full, half, ua, ub, sa, sb, cin, r, s;
        logic [4:0] nx;
        int w;
        nx = cur;
        if (sz == 2'b10 || op > 3'd4) return cur;
        w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        full = longint'(1) << w;
        half = full >> 1;
        ua   = longint'(a) & (full - 1);
        ub   = longint'(b) & (full - 1);
        sa   = (ua >= half) ? ua - full : ua;
        sb   = (ub >= half) ? ub - full : ub;
        cin  = ((op == 3'd3 || op == 3'd4) && cur[4]) ? 1 : 0;
        case (op)
            3'd0: begin
                nx[2] = (ua == ub);
                nx[0] = (ub < ua);
                nx[1] = (sb < sa);
            end
            3'd1, 3'd3: begin
                r = ua + ub + cin;
                s = sa + sb + cin;
                nx[4] = (r >= full);
                nx[3] = (s >= half) || (s < -half);
            end
            default: begin
                r = ub - ua - cin;
                s = sb - sa - cin;
                nx[4] = (r < 0);
                nx[3] = (s >= half) || (s < -half);
            end
        endcase
        return nx;
    endfunction

    function automatic logic ref_cond(input logic [3:0] cc, input logic [4:0] fl);
        logic c, f, z, n, l;
        {c, f, z, n, l} = fl;
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return l;
            4'd5:  return !l;
            4'd6:  return n;
            4'd7:  return !n;
            4'd8:  return f;
            4'd9:  return !f;
            4'd10: return !(l | z);
            4'd11: return l | z;
            4'd12: return !(n | z);
            4'd13: return n | z;
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [4:0] exp_f, input logic exp_ct);
        logic [4:0] got;
        got = {flag_c, flag_f, flag_z, flag_n, flag_l};
        n_vec++;
        if (got !== exp_f || cond_true !== exp_ct) begin
            n_fail++;
            $display("FAIL %s: got cfznl=%b cond=%b, expected cfznl=%b cond=%b (cc=%0d)",
                     tag, got, cond_true, exp_f, exp_ct, cond_code);
        end
    endtask

    task automatic apply(input string tag, input logic v, input logic [2:0] op,
                         input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] cc);
        logic [4:0] e;
        @(negedge clk);
        op_valid = v; op_sel = op; size_code = sz;
        src_a = a; src_b = b; cond_code = cc;
        e = v ? ref_flags(op, sz, a, b, mflags) : mflags;
        @(negedge clk);
        op_valid = 1'b0;
        mflags = e;
        check(tag, e, ref_cond(cc, e));
    endtask

    function automatic string op_tag(input logic v, input logic [2:0] op, input logic [1:0] sz);
        if (!v) return "R9 idle hold";
        if (sz == 2'b10) return "R1 bad size";
        case (op)
            3'd0: return "R3 compare";
            3'd1: return "R6 add";
            3'd2: return "R7 subtract";
            3'd3, 3'd4: return "R8 carry-in";
            default: return "R2 reserved op";
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1;
        cond_code = 4'd1;
        repeat (3) @(negedge clk);
        // R10: flags cleared by reset, Z=0 test true
        check("R10 reset", 5'b0, 1'b1);
        rst = 1'b0;

        // R4: 8-bit compare whose difference overflows
        apply("R4 overflowing compare", 1, 3'd0, 2'b00, 32'h0000_0001, 32'h0000_0080, 4'd6);
        apply("R4 overflowing compare rev", 1, 3'd0, 2'b00, 32'h0000_0080, 32'h0000_007F, 4'd7);
        apply("R4 word compare", 1, 3'd0, 2'b11, 32'h7FFF_FFFF, 32'h8000_0000, 4'd13);
        // R6: carry and overflow on add
        apply("R6 add carry", 1, 3'd1, 2'b00, 32'h0000_00FF, 32'h0000_0001, 4'd2);
        apply("R6 add overflow", 1, 3'd1, 2'b01, 32'h0000_7FFF, 32'h0000_0001, 4'd8);
        // R5: compare keeps C and F
        apply("R5 compare keeps C/F", 1, 3'd0, 2'b11, 32'h5, 32'h5, 4'd0);
        // R8: carry folded in
        apply("R8 addc with carry", 1, 3'd1, 2'b11, 32'hFFFF_FFFF, 32'h1, 4'd2);
        apply("R8 addc uses C", 1, 3'd3, 2'b00, 32'h0000_00FE, 32'h0000_0001, 4'd2);
        apply("R8 subc borrow", 1, 3'd4, 2'b01, 32'h0, 32'h0, 4'd2);
        // R7: borrow and overflow on subtract
        apply("R7 sub borrow", 1, 3'd2, 2'b11, 32'h1, 32'h0, 4'd3);
        apply("R7 sub overflow", 1, 3'd2, 2'b00, 32'h01, 32'h80, 4'd8);
        // R1: high operand bits ignored, bad size holds
        apply("R1 high bits ignored", 1, 3'd0, 2'b00, 32'hAB00_0012, 32'h1200_0012, 4'd0);
        apply("R1 bad size holds", 1, 3'd0, 2'b10, 32'h1, 32'h2, 4'd0);
        // R2: reserved ops hold
        apply("R2 reserved op 5", 1, 3'd5, 2'b11, 32'h1, 32'h2, 4'd0);
        apply("R2 reserved op 7", 1, 3'd7, 2'b00, 32'hFF, 32'h0, 4'd0);

        // R12 / R11: sweep all codes on fixed flags without clocking an op
        apply("R3 compare for sweep", 1, 3'd0, 2'b11, 32'h10, 32'h3, 4'd4);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            cond_code = 4'(k);
            #1;
            check("R12/R11 cond sweep", mflags, ref_cond(4'(k), mflags));
        end

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic v; logic [2:0] op; logic [1:0] sz; logic [31:0] a, b; int pick;
            v    = ($urandom % 8) != 0;
            op   = (($urandom % 10) == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
            pick = $urandom % 12;
            sz   = (pick == 0) ? 2'b10 : (pick < 4) ? 2'b00 : (pick < 8) ? 2'b01 : 2'b11;
            a    = $urandom;
            b    = (($urandom % 5) == 0) ? a : $urandom;
            if (($urandom % 6) == 0) a = 32'h8000_0080;
            if (($urandom % 6) == 0) b = 32'h7FFF_7F7F;
            apply(op_tag(v, op, sz), v, op, sz, a, b, 4'($urandom));
        end

        // R10: reset mid-run clears flags again
        @(negedge clk);
        rst = 1'b1; cond_code = 4'd0;
        @(negedge clk);
        mflags = '0;
        check("R10 reset again", 5'b0, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: got no completion, expected completion before timeout");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule